// File: doc/BRIEF.md
# Nibble-Mode Parallel Register Slave

This block is the device end of a narrow host link that runs over an 8-bit parallel port. The host writes one byte at a time onto a data bus. The top three bits of each byte are a command code. The low four bits carry a register index or a data nibble. Bit 4 picks the upper or lower half of a byte. The host can write and read a fifteen-entry register file through this link. Read data comes back four bits at a time on status lines. When no command is open, the host can also stream bytes into an external packet buffer as pairs of nibbles.

The host bus is asynchronous to the block clock. It passes through a synchronizer, and a byte is acted on only when its value changes. A host may therefore repeat a byte to allow for slow line settling, and the repeat does nothing. Outside a command, the packet buffer write pointer steps by one after every completed byte. Writing register 14 reloads the pointer.

Top module: `npr_slave`

## Requirements
- R1: A synchronous active-high reset clears every register to 0x00, sets the buffer pointer to 0, drives status_lines to 0x00 and holds buf_we low.
- R2: A byte is decoded only when the synchronized bus value differs from the previous one. Repeating the same byte has no effect.
- R3: A byte with bits [7:5]=3'b010 opens a register write to index bits [3:0]. Each following byte with bits [7:5]=3'b000 stages its low nibble into the low half (bit 4 = 0) or the high half (bit 4 = 1). A byte with bits [7:5]=3'b111 commits the staged nibbles, and its own low bits are ignored. A read-address byte that arrives before the commit discards the staged write.
- R4: A byte with bits [7:5]=3'b110 selects register [3:0] for reading. Its bit 4 picks the high nibble (1) or the low nibble (0). The selected nibble appears on status_lines[6:3], and bits 7 and 2:0 stay 0.
- R5: The register file has indices 0 to 14. Index 15 reads as 0, and writes to it are discarded.
- R6: A write that stages only one half leaves the other half of the register unchanged.
- R7: With no command open, a 3'b000 byte with bit 4 = 0 holds its nibble as the low half. A 3'b000 byte with bit 4 = 1 issues one buffer write of {its nibble, held low nibble} at the pointer, and the pointer then advances by one. Register traffic issues no buffer writes.
- R8: A 16-bit word sent as four nibbles, least significant first, lands as two buffer writes to consecutive addresses, low byte first.
- R9: Committing a value to register 14 loads that value into the buffer pointer, and the register also reads back the value.
- R10: A 3'b111 byte closes a read, which returns status_lines to 0x00. Bytes with bits [7:5] of 3'b001, 3'b011, 3'b100 or 3'b101 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data | input | 8 | Asynchronous host data byte |
| status_lines | output | 8 | Read nibble on bits 6..3, other bits zero |
| buf_we | output | 1 | One-cycle packet buffer write strobe |
| buf_addr | output | BUF_AW | Packet buffer write address |
| buf_wdata | output | 8 | Packet buffer write byte |

## Verification
The bench builds the block with its default parameters: a fifteen-entry register file, an 8-bit buffer pointer, register 14 as the pointer-load register and a two-stage synchronizer. With these values, the index-15 hole and the reload of the pointer to 0x80 can both be reached. It also checks that four nibbles land at consecutive addresses. Repeated bytes sit between nibble pairs, so the bench can tell a skipped duplicate from a second buffer write.

// File: rtl/npr_pkg.sv
package npr_pkg;

    localparam int BYTE_W   = 8;
    localparam int NIB_W    = 4;
    localparam int IDX_W    = 4;
    localparam int STAT_LSB = 3;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hE0;

    typedef enum logic [2:0] {
        CMD_DATA,
        CMD_WADDR,
        CMD_RADDR,
        CMD_END,
        CMD_NONE
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WRITE,
        PH_READ
    } phase_e;

    typedef struct packed {
        cmd_e             cmd;
        logic             hi;
        logic [NIB_W-1:0] nib;
    } bus_word_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [1:0]       mask;
        logic [NIB_W-1:0] lo;
        logic [NIB_W-1:0] hi;
    } commit_t;

    typedef struct packed {
        logic             valid;
        logic             hi;
        logic [NIB_W-1:0] nib;
    } bulk_t;

    function automatic bus_word_t decode_byte(input logic [BYTE_W-1:0] b);
        bus_word_t w;
        w.hi  = b[4];
        w.nib = b[3:0];
        case (b[7:5])
            3'b111:  w.cmd = CMD_END;
            3'b010:  w.cmd = CMD_WADDR;
            3'b110:  w.cmd = CMD_RADDR;
            3'b000:  w.cmd = CMD_DATA;
            default: w.cmd = CMD_NONE;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/npr_bus_sync.sv
module npr_bus_sync #(
    parameter int W = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] bus_byte,
    output logic         bus_evt
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= RST_VAL;
                    else     stg[g] <= bus_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= RST_VAL;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= stg[STAGES-1];
    end

    assign bus_byte = stg[STAGES-1];
    assign bus_evt  = (stg[STAGES-1] != prev);
endmodule

// File: rtl/npr_cmd_fsm.sv
module npr_cmd_fsm
    import npr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_evt,
    input  logic [BYTE_W-1:0]        bus_byte,
    output commit_t                  cmt,
    output bulk_t                    blk,
    output logic                     rd_active,
    output logic [IDX_W-1:0]         rd_idx,
    output logic                     rd_hi
);
    bus_word_t        w;
    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             hi_sel;
    logic [NIB_W-1:0] pend_lo, pend_hi;
    logic [1:0]       dirty;

    assign w = decode_byte(bus_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            idx     <= '0;
            hi_sel  <= 1'b0;
            pend_lo <= '0;
            pend_hi <= '0;
            dirty   <= '0;
            cmt     <= '0;
            blk     <= '0;
        end else begin
            cmt.valid <= 1'b0;
            blk.valid <= 1'b0;
            if (bus_evt) begin
                case (w.cmd)
                    CMD_END: begin
                        cmt.valid <= (phase == PH_WRITE) && (dirty != 2'b00);
                        cmt.idx   <= idx;
                        cmt.mask  <= dirty;
                        cmt.lo    <= pend_lo;
                        cmt.hi    <= pend_hi;
                        phase     <= PH_IDLE;
                        idx       <= '0;
                        hi_sel    <= 1'b0;
                        dirty     <= '0;
                    end
                    CMD_WADDR: begin
                        phase  <= PH_WRITE;
                        idx    <= w.nib;
                        hi_sel <= w.hi;
                        dirty  <= '0;
                    end
                    CMD_RADDR: begin
                        phase  <= PH_READ;
                        idx    <= w.nib;
                        hi_sel <= w.hi;
                        dirty  <= '0;
                    end
                    CMD_DATA: begin
                        if (phase == PH_WRITE) begin
                            if (w.hi) begin
                                pend_hi  <= w.nib;
                                dirty[1] <= 1'b1;
                            end else begin
                                pend_lo  <= w.nib;
                                dirty[0] <= 1'b1;
                            end
                        end else if (phase == PH_IDLE) begin
                            blk.valid <= 1'b1;
                            blk.hi    <= w.hi;
                            blk.nib   <= w.nib;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_active = (phase == PH_READ);
    assign rd_idx    = idx;
    assign rd_hi     = hi_sel;
endmodule

// File: rtl/npr_regfile.sv
module npr_regfile
    import npr_pkg::*;
#(
    parameter int NUM_REGS = 15,
    parameter int PTR_REG  = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  commit_t           cmt,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_hi,
    output logic [NIB_W-1:0]  rd_nib,
    output logic              ptr_load,
    output logic [BYTE_W-1:0] ptr_val
);
    logic [BYTE_W-1:0] mem [NUM_REGS];
    logic [BYTE_W-1:0] old_val, new_val, rd_byte;
    logic              idx_ok;

    always_comb begin
        old_val = '0;
        rd_byte = '0;
        idx_ok  = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (cmt.idx == IDX_W'(i)) begin
                old_val = mem[i];
                idx_ok  = 1'b1;
            end
            if (rd_idx == IDX_W'(i)) rd_byte = mem[i];
        end
        new_val[3:0] = cmt.mask[0] ? cmt.lo : old_val[3:0];
        new_val[7:4] = cmt.mask[1] ? cmt.hi : old_val[7:4];
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    mem[g] <= '0;
                else if (cmt.valid && cmt.idx == IDX_W'(g))
                    mem[g] <= new_val;
            end
        end
    endgenerate

    assign rd_nib   = rd_hi ? rd_byte[7:4] : rd_byte[3:0];
    assign ptr_load = cmt.valid && idx_ok && (cmt.idx == IDX_W'(PTR_REG));
    assign ptr_val  = new_val;
endmodule

// File: rtl/npr_bulk.sv
module npr_bulk
    import npr_pkg::*;
#(
    parameter int BUF_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bulk_t             blk,
    input  logic              ptr_load,
    input  logic [BYTE_W-1:0] ptr_val,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [BYTE_W-1:0] buf_wdata
);
    logic [NIB_W-1:0]  lo_hold;
    logic [BUF_AW-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_hold   <= '0;
            ptr       <= '0;
            buf_we    <= 1'b0;
            buf_addr  <= '0;
            buf_wdata <= '0;
        end else begin
            buf_we <= 1'b0;
            if (ptr_load) begin
                ptr <= BUF_AW'(ptr_val);
            end else if (blk.valid) begin
                if (blk.hi) begin
                    buf_we    <= 1'b1;
                    buf_addr  <= ptr;
                    buf_wdata <= {blk.nib, lo_hold};
                    ptr       <= ptr + 1'b1;
                end else begin
                    lo_hold <= blk.nib;
                end
            end
        end
    end
endmodule

// File: rtl/npr_slave.sv
module npr_slave
    import npr_pkg::*;
#(
    parameter int NUM_REGS    = 15,
    parameter int PTR_REG     = 14,
    parameter int BUF_AW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        host_data,
    output logic [7:0]        status_lines,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_addr,
    output logic [7:0]        buf_wdata
);
    logic [BYTE_W-1:0] bus_byte;
    logic              bus_evt;
    commit_t           cmt;
    bulk_t             blk;
    logic              rd_active, rd_hi;
    logic [IDX_W-1:0]  rd_idx;
    logic [NIB_W-1:0]  rd_nib;
    logic              ptr_load;
    logic [BYTE_W-1:0] ptr_val;
    logic              cmt_fire;

    npr_bus_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_BYTE)) u_sync (
        .clk(clk), .rst(rst), .bus_in(host_data),
        .bus_byte(bus_byte), .bus_evt(bus_evt)
    );

    npr_cmd_fsm u_fsm (
        .clk(clk), .rst(rst), .bus_evt(bus_evt), .bus_byte(bus_byte),
        .cmt(cmt), .blk(blk), .rd_active(rd_active),
        .rd_idx(rd_idx), .rd_hi(rd_hi)
    );

    npr_regfile #(.NUM_REGS(NUM_REGS), .PTR_REG(PTR_REG)) u_regs (
        .clk(clk), .rst(rst), .cmt(cmt), .rd_idx(rd_idx), .rd_hi(rd_hi),
        .rd_nib(rd_nib), .ptr_load(ptr_load), .ptr_val(ptr_val)
    );

    npr_bulk #(.BUF_AW(BUF_AW)) u_bulk (
        .clk(clk), .rst(rst), .blk(blk), .ptr_load(ptr_load), .ptr_val(ptr_val),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata)
    );

    assign cmt_fire = cmt.valid;

    always_comb begin
        status_lines = '0;
        if (rd_active) status_lines[STAT_LSB +: NIB_W] = rd_nib;
    end
endmodule

// File: rtl/npr_slave_chk.sv
module npr_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] status_lines,
    input logic       buf_we,
    input logic       evt,
    input logic [7:0] evt_byte,
    input logic       cmt_fire
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (status_lines == 8'h00 && !buf_we)); // R1
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(evt) && !$past(cmt_fire) && !$past(rst)) |-> $stable(status_lines)); // R2
    AST_PUSH_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> $past(evt, 2)); // R2
    AST_COMMIT_ON_END: assert property (@(posedge clk) disable iff (rst)
        cmt_fire |-> ($past(evt) && $past(evt_byte[7:5]) == 3'b111)); // R3
    AST_SIDE_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status_lines[7] == 1'b0 && status_lines[2:0] == 3'b000)); // R4
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> !buf_we); // R7
endmodule

bind npr_slave npr_slave_chk u_chk (
    .clk(clk), .rst(rst), .status_lines(status_lines), .buf_we(buf_we),
    .evt(bus_evt), .evt_byte(bus_byte), .cmt_fire(cmt_fire)
);

// File: tb/test_npr_slave.sv
module test_npr_slave;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_data = 8'hE0;
    logic [7:0] status_lines;
    logic       buf_we;
    logic [7:0] buf_addr;
    logic [7:0] buf_wdata;

    int         n_run = 0;
    int         n_fail = 0;
    int         push_cnt = 0;
    logic [7:0] last_addr = '0;
    logic [7:0] last_data = '0;

    always #10 clk = ~clk;

    npr_slave i_npr_slave (
        .clk(clk), .rst(rst), .host_data(host_data), .status_lines(status_lines),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata)
    );

    always @(negedge clk) begin
        if (buf_we) begin
            push_cnt  <= push_cnt + 1;
            last_addr <= buf_addr;
            last_data <= buf_wdata;
        end
    end

    // {check flag, requirement number, byte driven, expected status_lines}
    localparam int NV = 30;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 4'd0,  8'hE0, 8'h00},
        {1'b0, 4'd3,  8'h43, 8'h00},
        {1'b0, 4'd3,  8'h0A, 8'h00},
        {1'b0, 4'd3,  8'h15, 8'h00},
        {1'b0, 4'd3,  8'hE0, 8'h00},
        {1'b1, 4'd3,  8'hC3, 8'h50},  // R3 commit 0x5A, low nibble
        {1'b1, 4'd4,  8'hD3, 8'h28},  // R4 high nibble
        {1'b1, 4'd10, 8'hE0, 8'h00},  // R10 read closed
        {1'b0, 4'd3,  8'h4D, 8'h00},
        {1'b0, 4'd3,  8'h07, 8'h00},
        {1'b0, 4'd3,  8'hE3, 8'h00},
        {1'b1, 4'd3,  8'hCD, 8'h38},  // R3 end byte low bits ignored
        {1'b0, 4'd6,  8'hE0, 8'h00},
        {1'b0, 4'd6,  8'h53, 8'h00},
        {1'b0, 4'd6,  8'h19, 8'h00},
        {1'b0, 4'd6,  8'hE0, 8'h00},
        {1'b1, 4'd6,  8'hC3, 8'h50},  // R6 low half kept
        {1'b1, 4'd6,  8'hD3, 8'h48},  // R6 high half replaced
        {1'b0, 4'd5,  8'hE0, 8'h00},
        {1'b0, 4'd5,  8'h4F, 8'h00},
        {1'b0, 4'd5,  8'h0C, 8'h00},
        {1'b0, 4'd5,  8'hE0, 8'h00},
        {1'b1, 4'd5,  8'hCF, 8'h00},  // R5 index 15 hole
        {1'b0, 4'd3,  8'hE0, 8'h00},
        {1'b0, 4'd3,  8'h43, 8'h00},
        {1'b0, 4'd3,  8'h01, 8'h00},
        {1'b1, 4'd3,  8'hC3, 8'h50},  // R3 staged write discarded
        {1'b1, 4'd10, 8'h23, 8'h50},  // R10 pattern 001 ignored
        {1'b1, 4'd10, 8'h7F, 8'h50},  // R10 pattern 011 ignored
        {1'b1, 4'd10, 8'hE0, 8'h00}   // R10 read closed
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        host_data = b;
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 status in reset", status_lines, 8'h00);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            put(VEC[i][15:8]);
            if (VEC[i][20])
                check($sformatf("R%0d vec %0d", VEC[i][19:16], i), status_lines, VEC[i][7:0]);
        end
        check("R7 no buffer writes from register traffic", push_cnt, 0);

        // R7 bulk byte at pointer 0
        put(8'h0B); put(8'h1C);
        check("R7 push count", push_cnt, 1);
        check("R7 addr", last_addr, 8'h00);
        check("R7 data", last_data, 8'hCB);

        // R2 repeated bytes give no second write
        put(8'h03); put(8'h03);
        check("R2 low repeat no push", push_cnt, 1);
        put(8'h14); put(8'h14);
        check("R2 single push", push_cnt, 2);
        check("R2 data", last_data, 8'h43);
        check("R2 addr", last_addr, 8'h01);

        // R8 word 0x1234
        put(8'h04); put(8'h13);
        check("R8 low byte", {last_addr, last_data}, 16'h0234);
        put(8'h02); put(8'h11);
        check("R8 high byte", {last_addr, last_data}, 16'h0312);
        check("R8 count", push_cnt, 4);

        // R9 pointer reload via register 14
        put(8'h4E); put(8'h00); put(8'h18); put(8'hE0);
        check("R9 no push from reg write", push_cnt, 4);
        put(8'h06); put(8'h17);
        check("R9 reloaded addr", last_addr, 8'h80);
        check("R9 data", last_data, 8'h76);
        put(8'hDE);
        check("R9 reg readback", status_lines, 8'h40);
        put(8'hD3);
        check("R4 read before reset", status_lines, 8'h48);

        // R1 reset mid-read
        @(negedge clk);
        rst = 1'b1;
        host_data = 8'hE0;
        repeat (2) @(negedge clk);
        check("R1 status cleared", status_lines, 8'h00);
        check("R1 buf_we low", buf_we, 1'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        put(8'hC3);
        check("R1 register cleared", status_lines, 8'h00);
        put(8'hE0);
        put(8'h0A); put(8'h1B);
        check("R1 pointer back to zero", {last_addr, last_data}, 16'h00BA);

        finish_run();
    end
endmodule